// File: doc/BRIEF.md
# Modem Line Status and Change-Interrupt Register

This block is the receiver-side control/status word of an asynchronous serial line interface with modem control. It watches four modem input lines (carrier detect, clear to send, secondary receive and ring) and shows their levels in a 16-bit word that software reads. It also holds three modem output levels that software writes: data terminal ready, request to send and secondary transmit.

The most significant bit is a change flag. Three lines set it on either edge, and ring sets it only on its rising edge. Reading the word clears the flag, so each change is reported once. When the flag is set and the change-interrupt enable bit is set, the block raises an interrupt request. The flag is a two-state machine. `ST_QUIET` moves to `ST_PENDING` on any qualified line event. `ST_PENDING` moves to `ST_QUIET` on a read that does not coincide with an event. The init pulse forces `ST_QUIET` from either state.

Each modem input passes through a two-flop synchronizer before it is shown or compared. The serial receiver itself, address decoding and interrupt vector delivery are outside this block. The receiver's busy indication enters as a plain level and is shown in the word.

Top module: `modem_ctl_reg`

## Requirements
- R1: Read word bits 14, 13, 12 and 10 show the synchronized ring, clear to send, carrier detect and secondary receive inputs, two clock edges after an input changes. Bit 11 shows the `rx_busy` input directly.
- R2: A 0-to-1 or 1-to-0 change on carrier detect, clear to send or secondary receive sets the change flag (bit 15). The flag becomes visible on the third clock edge after the input changes.
- R3: A 0-to-1 change on ring sets the change flag with the same latency. A 1-to-0 change on ring leaves the flag unchanged.
- R4: A read (`rd_en` high for one cycle) returns the current flag in bit 15 and clears the flag at that clock edge.
- R5: If a qualified line event and a read fall on the same clock edge, the flag is set after that edge.
- R6: `irq_out` is high exactly when the change flag and the interrupt enable (bit 5) are both set.
- R7: `init` clears the change flag, the interrupt enable, request to send and secondary transmit. `init` leaves data terminal ready unchanged.
- R8: A write (`wr_en`) loads bit 1 into data terminal ready, bit 2 into request to send, bit 3 into secondary transmit and bit 5 into the interrupt enable. Each value appears on its output and in the read word after the write edge.
- R9: Bits 9..6, 4 and 0 always read as 0. Write data in bits 15..10 has no effect on the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init | input | 1 | System initialization pulse, active high, synchronous |
| wr_en | input | 1 | Write strobe for the control bits |
| wr_data | input | 16 | Write data word |
| rd_en | input | 1 | Read strobe; clears the change flag |
| rd_data | output | 16 | Read data word |
| rx_busy | input | 1 | Receiver busy level from the serial receiver |
| dcd_in | input | 1 | Carrier detect from the modem (asynchronous) |
| cts_in | input | 1 | Clear to send from the modem (asynchronous) |
| srx_in | input | 1 | Secondary receive from the modem (asynchronous) |
| ring_in | input | 1 | Ring indicator from the modem (asynchronous) |
| dtr_out | output | 1 | Data terminal ready level |
| rts_out | output | 1 | Request to send level |
| stx_out | output | 1 | Secondary transmit level (1 drives a space) |
| irq_out | output | 1 | Change interrupt request |

## Verification
The random phase toggles arbitrary subsets of the four lines, interleaved with reads. This separates lines that set the flag on both edges from ring, which sets it only on its rising edge. Directed cases cover a lone ring falling edge, which must leave the flag clear. They also cover a read that falls on the same edge as an event, which must leave the flag set. Interrupt enable on and off is tried with the flag both set and clear. An init pulse is applied with every control bit set, to show that data terminal ready survives while the others clear.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    typedef enum logic {ST_QUIET, ST_PENDING} flag_state_t;

    localparam int WORD_W   = 16;
    localparam int N_LINES  = 4;
    // line index inside the synchronized vector
    localparam int L_DCD    = 0;
    localparam int L_CTS    = 1;
    localparam int L_SRX    = 2;
    localparam int L_RING   = 3;
    // word bit positions
    localparam int B_CHG    = 15;
    localparam int B_RING   = 14;
    localparam int B_CTS    = 13;
    localparam int B_DCD    = 12;
    localparam int B_RXBUSY = 11;
    localparam int B_SRX    = 10;
    localparam int B_IE     = 5;
    localparam int B_STX    = 3;
    localparam int B_RTS    = 2;
    localparam int B_DTR    = 1;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         init,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (init) chain[0] <= '0;
        else      chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (init) chain[s] <= '0;
            else      chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge #(
    parameter int           W         = 4,
    parameter logic [W-1:0] RISE_ONLY = '0
) (
    input  logic         clk,
    input  logic         init,
    input  logic [W-1:0] cur,
    output logic         any_evt
);
    logic [W-1:0] prev;
    logic [W-1:0] evt;

    always_ff @(posedge clk) begin
        if (init) prev <= '0;
        else      prev <= cur;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        if (RISE_ONLY[i]) begin : g_rise
            assign evt[i] = cur[i] & ~prev[i];
        end else begin : g_both
            assign evt[i] = cur[i] ^ prev[i];
        end
    end

    assign any_evt = |evt;
endmodule

// File: rtl/mdm_flag_fsm.sv
module mdm_flag_fsm
    import mdm_pkg::*;
(
    input  logic clk,
    input  logic init,
    input  logic any_evt,
    input  logic rd_en,
    output logic flag
);
    flag_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (init) state <= ST_QUIET;
        else      state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET:   if (any_evt) state_nx = ST_PENDING;
            ST_PENDING: if (rd_en && !any_evt) state_nx = ST_QUIET;
            default:    state_nx = ST_QUIET;
        endcase
    end

    always_comb begin
        flag = (state == ST_PENDING);
    end
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              init,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              rx_busy,
    input  logic              dcd_in,
    input  logic              cts_in,
    input  logic              srx_in,
    input  logic              ring_in,
    output logic              dtr_out,
    output logic              rts_out,
    output logic              stx_out,
    output logic              irq_out
);
    localparam logic [N_LINES-1:0] RISE_MASK = N_LINES'(1) << L_RING;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               any_evt;
    logic               chg_flag;
    logic               ie_q, rts_q, stx_q, dtr_q;

    always_comb begin
        raw_lines         = '0;
        raw_lines[L_DCD]  = dcd_in;
        raw_lines[L_CTS]  = cts_in;
        raw_lines[L_SRX]  = srx_in;
        raw_lines[L_RING] = ring_in;
    end

    mdm_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .init(init), .d(raw_lines), .q(sync_lines)
    );

    mdm_edge #(.W(N_LINES), .RISE_ONLY(RISE_MASK)) u_edge (
        .clk (clk), .init(init), .cur(sync_lines), .any_evt(any_evt)
    );

    mdm_flag_fsm u_fsm (
        .clk (clk), .init(init), .any_evt(any_evt), .rd_en(rd_en), .flag(chg_flag)
    );

    always_ff @(posedge clk) begin
        if (init) begin
            ie_q  <= 1'b0;
            rts_q <= 1'b0;
            stx_q <= 1'b0;
        end else if (wr_en) begin
            ie_q  <= wr_data[B_IE];
            rts_q <= wr_data[B_RTS];
            stx_q <= wr_data[B_STX];
        end
    end

    // terminal ready is software-owned only: no init term
    always_ff @(posedge clk) begin
        if (wr_en) dtr_q <= wr_data[B_DTR];
    end

    always_comb begin
        rd_data           = '0;
        rd_data[B_CHG]    = chg_flag;
        rd_data[B_RING]   = sync_lines[L_RING];
        rd_data[B_CTS]    = sync_lines[L_CTS];
        rd_data[B_DCD]    = sync_lines[L_DCD];
        rd_data[B_RXBUSY] = rx_busy;
        rd_data[B_SRX]    = sync_lines[L_SRX];
        rd_data[B_IE]     = ie_q;
        rd_data[B_STX]    = stx_q;
        rd_data[B_RTS]    = rts_q;
        rd_data[B_DTR]    = dtr_q;
    end

    assign dtr_out = dtr_q;
    assign rts_out = rts_q;
    assign stx_out = stx_q;
    assign irq_out = chg_flag & ie_q;
endmodule

// File: rtl/modem_ctl_reg_chk.sv
module modem_ctl_reg_chk (
    input logic        clk,
    input logic        init,
    input logic        wr_en,
    input logic        rd_en,
    input logic        any_evt,
    input logic [15:0] rd_data,
    input logic        irq_out,
    input logic        dtr_out,
    input logic        rts_out,
    input logic        stx_out
);
    a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (init)
        any_evt |=> rd_data[15]);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (init)
        (rd_en && !any_evt) |=> !rd_data[15]);

    a_r5_event_beats_read: assert property (@(posedge clk) disable iff (init)
        (rd_en && any_evt) |=> rd_data[15]);

    a_r6_no_irq_disabled: assert property (@(posedge clk) disable iff (init)
        !rd_data[5] |-> !irq_out);

    a_r6_irq_when_armed: assert property (@(posedge clk) disable iff (init)
        (rd_data[5] && rd_data[15]) |-> irq_out);

    a_r7_init_clears: assert property (@(posedge clk)
        init |=> (!rd_data[15] && !rts_out && !stx_out && !irq_out));

    a_r7_dtr_kept: assert property (@(posedge clk)
        (init && !wr_en) |=> $stable(dtr_out));

    always @(negedge clk) begin
        a_r9_zero_bits: assert (rd_data[9:6] == 4'b0 && rd_data[4] == 1'b0 && rd_data[0] == 1'b0);
    end
endmodule

bind modem_ctl_reg modem_ctl_reg_chk u_chk (
    .clk     (clk),
    .init    (init),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .any_evt (any_evt),
    .rd_data (rd_data),
    .irq_out (irq_out),
    .dtr_out (dtr_out),
    .rts_out (rts_out),
    .stx_out (stx_out)
);

// File: tb/modem_ctl_reg_test.sv
`timescale 1ns/1ps
module modem_ctl_reg_test;
    logic        clk = 1'b0;
    logic        init = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rx_busy = 1'b0;
    logic        dcd_in = 1'b0, cts_in = 1'b0, srx_in = 1'b0, ring_in = 1'b0;
    logic        dtr_out, rts_out, stx_out, irq_out;

    int checks = 0;
    int errors = 0;
    logic       exp_flag = 1'b0;
    logic       exp_ie = 1'b0;
    logic [3:0] lines = '0; // {ring, srx, cts, dcd}

    always #10 clk = ~clk; // 50 MHz

    modem_ctl_reg uut (
        .clk(clk), .init(init), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_busy(rx_busy),
        .dcd_in(dcd_in), .cts_in(cts_in), .srx_in(srx_in), .ring_in(ring_in),
        .dtr_out(dtr_out), .rts_out(rts_out), .stx_out(stx_out), .irq_out(irq_out)
    );

    function automatic logic causes_event(input logic [3:0] o, input logic [3:0] n);
        return ((o[2:0] ^ n[2:0]) != 3'b0) || (!o[3] && n[3]);
    endfunction

    function automatic logic [4:0] status_bits(input logic [3:0] l, input logic busy);
        // {ring, cts, dcd, busy, srx} for word bits 14..10
        return {l[3], l[1], l[0], busy, l[2]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic drive_lines(input logic [3:0] n);
        {ring_in, srx_in, cts_in, dcd_in} = n;
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_data = d; wr_en = 1'b1; tick(); wr_en = 1'b0;
    endtask

    task automatic do_read(output logic [15:0] v);
        rd_en = 1'b1; #1 v = rd_data; tick(); rd_en = 1'b0;
    endtask

    task automatic settle_lines(input logic [3:0] n);
        exp_flag = exp_flag | causes_event(lines, n);
        lines = n;
        drive_lines(n);
        repeat (4) tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) tick();
        init = 1'b0;
        tick();
        // R7 reset state
        check("R7 reset word", {16'b0, rd_data & 16'hFC2C}, 32'h0);
        check("R7 reset irq", irq_out, 0);

        // R8 writes, R9 ignored high bits
        do_write(16'hFC2E);
        exp_ie = 1'b1;
        check("R8 dtr", dtr_out, 1); check("R8 rts", rts_out, 1); check("R8 stx", stx_out, 1);
        check("R9 ro bits unaffected", rd_data, 16'h002E);

        // R7 init keeps dtr
        init = 1'b1; tick(); init = 1'b0; exp_ie = 1'b0;
        check("R7 after init", rd_data, 16'h0002);
        check("R7 dtr kept", dtr_out, 1);

        // R1 rx_busy direct
        rx_busy = 1'b1; #1 check("R1 busy bit", rd_data[11], 1); rx_busy = 1'b0;

        // R3 ring fall alone leaves flag clear
        settle_lines(4'b1000);
        check("R3 ring rise sets", rd_data[15], 1);
        do_read(v); exp_flag = 1'b0;
        check("R4 read returns flag", v[15], 1);
        check("R4 flag cleared", rd_data[15], 0);
        settle_lines(4'b0000);
        check("R3 ring fall no flag", rd_data[15], exp_flag);

        // R2 latency: visible at third edge, not before
        drive_lines(4'b0001); lines = 4'b0001;
        tick(); tick();
        #1 check("R1 status after two edges", rd_data[12], 1);
        check("R2 flag not yet", rd_data[15], 0);
        tick();
        check("R2 flag after three edges", rd_data[15], 1);
        do_read(v); exp_flag = 1'b0;

        // R5 read coinciding with event
        drive_lines(4'b0011); lines = 4'b0011;
        tick(); tick();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        check("R5 event beats read", rd_data[15], 1);
        exp_flag = 1'b1;

        // R6 irq with enable
        check("R6 irq disabled", irq_out, 0);
        do_write(16'h0020); exp_ie = 1'b1;
        check("R6 irq enabled", irq_out, 1);

        // random phase
        for (int it = 0; it < 300; it++) begin
            logic [3:0] n;
            if ($urandom_range(0, 2) == 0) begin
                do_read(v);
                check("R4 random read", v[15], exp_flag);
                exp_flag = 1'b0;
                check("R4 random clear", rd_data[15], 0);
            end
            if ($urandom_range(0, 5) == 0) begin
                exp_ie = $urandom_range(0, 1);
                do_write({10'b0, exp_ie, 5'b0});
            end
            n = 4'($urandom_range(0, 15));
            settle_lines(n);
            check("R1 random status", rd_data[14:10], status_bits(lines, 1'b0));
            check("R2 R3 random flag", rd_data[15], exp_flag);
            check("R6 random irq", irq_out, exp_flag & exp_ie);
            check("R9 random zero bits", {rd_data[9:6], rd_data[4], rd_data[0]}, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule